// File: doc/BRIEF.md
# Authentication Key State Bank

This block keeps two 128-bit working registers for an AES engine that runs authenticated modes. One slot holds the hash subkey that the engine computes for the Galois-field hash in GCM. The other slot holds the running authentication value that the engine accumulates during GCM and CCM. Only the engine loads real values into the slots, through its own write port. Both slots drive the datapath through full-width read outputs that change in the same cycle as the slot.

The host bus sees the two slots as eight write-only 32-bit words. The hash subkey slot sits at byte addresses 0x500, 0x504, 0x508 and 0x50C. The authentication slot sits at 0x510, 0x514, 0x518 and 0x51C. A host write to any of the four words of a slot is a clear command: the whole slot goes to zero and the written data is discarded. Software uses this to wipe stale state before it reuses a key without reloading it. Host reads always return zero. A key-load pulse from the key store clears both slots at once.

Top module: `auth_key_bank`

## Requirements
- R1: While rst_ni is low, both hkey_o and auth_o are all zeroes.
- R2: A host write (host_valid_i=1, host_we_i=1) to byte address 0x500, 0x504, 0x508 or 0x50C makes hkey_o zero on the next clock, whatever host_wdata_i holds.
- R3: A host write to byte address 0x510, 0x514, 0x518 or 0x51C makes auth_o zero on the next clock, whatever host_wdata_i holds.
- R4: A host write to one slot leaves the other slot unchanged. A host cycle with host_valid_i=0, an address outside 0x500 to 0x51F, or an address with bits 1:0 not 00 changes neither slot.
- R5: host_rdata_o is zero at all times, and a host read (host_we_i=0) changes neither slot.
- R6: When eng_hkey_we_i (or eng_auth_we_i) is 1 and no clear applies to that slot, hkey_o (or auth_o) equals eng_hkey_i (or eng_auth_i) after the next clock. Bit 31:0 of a slot is its word at the lowest address and bits 127:96 its word at the highest address.
- R7: key_load_i=1 makes both hkey_o and auth_o zero on the next clock.
- R8: A host clear and an engine write to the same slot in one cycle leave that slot at zero.
- R9: key_load_i and an engine write in one cycle leave both slots at zero.
- R10: With no host clear, key load or engine write for a slot, that slot keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_valid_i | input | 1 | Host access valid |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | 12 | Host byte address |
| host_wdata_i | input | 32 | Host write data, discarded |
| host_rdata_o | output | 32 | Host read data, always zero |
| eng_hkey_we_i | input | 1 | Engine load of the hash subkey slot |
| eng_hkey_i | input | 128 | Engine hash subkey value |
| eng_auth_we_i | input | 1 | Engine load of the authentication slot |
| eng_auth_i | input | 128 | Engine authentication value |
| key_load_i | input | 1 | Key-load pulse, clears both slots |
| hkey_o | output | 128 | Hash subkey slot to datapath |
| auth_o | output | 128 | Authentication slot to datapath |

## Verification
The engine write port and a clear, from the host word write or from the key-load pulse, can fall on the same slot in the same cycle. The bench provokes this on purpose in directed steps, with a host write to each slot and a key-load pulse applied together with an engine write of non-zero data. It also mixes all three sources at random for several hundred cycles. A behavioural model gives clears priority, and every slot is compared with it after each clock edge.

// File: rtl/akb_pkg.sv
package akb_pkg;
  localparam int unsigned NUM_SLOTS = 2;

  typedef enum logic [0:0] {
    SLOT_HKEY = 1'b0,
    SLOT_AUTH = 1'b1
  } slot_e;
endpackage

// File: rtl/akb_host_decode.sv
module akb_host_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WORDS     = 4,
  parameter int unsigned NUM_SLOTS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h500
) (
  input  logic                 valid_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_SLOTS-1:0] clr_o
);
  localparam int unsigned BYTES   = DATA_W / 8;
  localparam int unsigned LSB_W   = $clog2(BYTES);
  localparam int unsigned SPAN    = WORDS * BYTES;
  localparam int unsigned SPAN_SH = $clog2(SPAN);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] slot_idx;
  logic              wr_hit;

  assign off      = addr_i - BASE_ADDR;
  assign slot_idx = off >> SPAN_SH;
  // aligned host write at or above the base; slot index filters the top end
  assign wr_hit   = valid_i && we_i && (addr_i[LSB_W-1:0] == '0) && (addr_i >= BASE_ADDR);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_dec
    assign clr_o[g] = wr_hit && (slot_idx == ADDR_W'(g));
  end
endmodule

// File: rtl/akb_slot.sv
module akb_slot #(
  parameter int unsigned W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // clear wins over load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else if (ld_i)  q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/auth_key_bank.sv
module auth_key_bank
  import akb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned KEY_W  = 128,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_valid_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              eng_hkey_we_i,
  input  logic [KEY_W-1:0]  eng_hkey_i,
  input  logic              eng_auth_we_i,
  input  logic [KEY_W-1:0]  eng_auth_i,
  input  logic              key_load_i,
  output logic [KEY_W-1:0]  hkey_o,
  output logic [KEY_W-1:0]  auth_o
);
  localparam int unsigned WORDS = KEY_W / DATA_W;

  logic [NUM_SLOTS-1:0] host_clr;
  logic [NUM_SLOTS-1:0] slot_clr;
  logic [NUM_SLOTS-1:0] slot_ld;
  logic [KEY_W-1:0]     slot_d [NUM_SLOTS];
  logic [KEY_W-1:0]     slot_q [NUM_SLOTS];
  logic                 unused_wdata;

  // host data never reaches storage
  assign unused_wdata = ^host_wdata_i;
  assign host_rdata_o = '0;

  akb_host_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WORDS     (WORDS),
    .NUM_SLOTS (NUM_SLOTS),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .valid_i (host_valid_i),
    .we_i    (host_we_i),
    .addr_i  (host_addr_i),
    .clr_o   (host_clr)
  );

  assign slot_ld[int'(SLOT_HKEY)] = eng_hkey_we_i;
  assign slot_ld[int'(SLOT_AUTH)] = eng_auth_we_i;
  assign slot_d[int'(SLOT_HKEY)]  = eng_hkey_i;
  assign slot_d[int'(SLOT_AUTH)]  = eng_auth_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_clr[g] = host_clr[g] | key_load_i;

    akb_slot #(.W(KEY_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (slot_clr[g]),
      .ld_i   (slot_ld[g]),
      .d_i    (slot_d[g]),
      .q_o    (slot_q[g])
    );
  end

  assign hkey_o = slot_q[int'(SLOT_HKEY)];
  assign auth_o = slot_q[int'(SLOT_AUTH)];
endmodule

// File: rtl/auth_key_bank_chk.sv
module auth_key_bank_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned KEY_W  = 128,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h500
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_valid_i,
  input logic              host_we_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              eng_hkey_we_i,
  input logic [KEY_W-1:0]  eng_hkey_i,
  input logic              eng_auth_we_i,
  input logic [KEY_W-1:0]  eng_auth_i,
  input logic              key_load_i,
  input logic [KEY_W-1:0]  hkey_o,
  input logic [KEY_W-1:0]  auth_o
);
  localparam int unsigned SPAN = (KEY_W / DATA_W) * (DATA_W / 8);
  localparam logic [ADDR_W-1:0] H_LO = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_LO = BASE_ADDR + ADDR_W'(SPAN);
  localparam logic [ADDR_W-1:0] A_HI = BASE_ADDR + ADDR_W'(2 * SPAN);

  logic hw, hit_h, hit_a;
  assign hw    = host_valid_i && host_we_i && (host_addr_i[1:0] == 2'b00);
  assign hit_h = hw && host_addr_i >= H_LO && host_addr_i < A_LO;
  assign hit_a = hw && host_addr_i >= A_LO && host_addr_i < A_HI;

  always_comb begin
    if (!rst_ni) begin
      assert_reset_zero_R1: assert (hkey_o == '0 && auth_o == '0);
    end
  end

  assert_hkey_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_h |=> hkey_o == '0);
  assert_auth_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_a |=> auth_o == '0);
  assert_isolate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_a && !key_load_i && !eng_hkey_we_i) |=> $stable(hkey_o));
  assert_rdata_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdata_o == '0);
  assert_eng_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_auth_we_i && !hit_a && !key_load_i) |=> auth_o == $past(eng_auth_i));
  assert_key_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_load_i |=> (hkey_o == '0 && auth_o == '0));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_h && !key_load_i && !eng_hkey_we_i) |=> $stable(hkey_o));
endmodule

bind auth_key_bank auth_key_bank_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .KEY_W     (KEY_W),
  .BASE_ADDR (BASE_ADDR)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_valid_i  (host_valid_i),
  .host_we_i     (host_we_i),
  .host_addr_i   (host_addr_i),
  .host_rdata_o  (host_rdata_o),
  .eng_hkey_we_i (eng_hkey_we_i),
  .eng_hkey_i    (eng_hkey_i),
  .eng_auth_we_i (eng_auth_we_i),
  .eng_auth_i    (eng_auth_i),
  .key_load_i    (key_load_i),
  .hkey_o        (hkey_o),
  .auth_o        (auth_o)
);

// File: tb/auth_key_bank_tb_top.sv
module auth_key_bank_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         host_valid_i, host_we_i;
  logic [11:0]  host_addr_i;
  logic [31:0]  host_wdata_i, host_rdata_o;
  logic         eng_hkey_we_i, eng_auth_we_i, key_load_i;
  logic [127:0] eng_hkey_i, eng_auth_i, hkey_o, auth_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [127:0] m_h, m_a;

  always #4 clk_i = ~clk_i;

  auth_key_bank dut_i (.*);

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic step(input logic v, input logic we, input logic [11:0] a,
                      input logic hwe, input logic [127:0] hd,
                      input logic awe, input logic [127:0] ad,
                      input logic kl, input string tag);
    bit hit, ch, ca;
    host_valid_i = v; host_we_i = we; host_addr_i = a; host_wdata_i = $urandom();
    eng_hkey_we_i = hwe; eng_hkey_i = hd;
    eng_auth_we_i = awe; eng_auth_i = ad; key_load_i = kl;
    hit = v && we && (a[1:0] == 2'b00);
    ch  = hit && int'(a) >= 'h500 && int'(a) < 'h510;
    ca  = hit && int'(a) >= 'h510 && int'(a) < 'h520;
    #1 check({tag, " R5 rdata"}, {96'd0, host_rdata_o}, 128'd0);
    if (kl || ch) m_h = '0; else if (hwe) m_h = hd;
    if (kl || ca) m_a = '0; else if (awe) m_a = ad;
    @(negedge clk_i);
    check({tag, " hkey"}, hkey_o, m_h);
    check({tag, " auth"}, auth_o, m_a);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 12'h0, 0, '0, 0, '0, 0, tag);
  endtask

  task automatic fill(input string tag);
    step(0, 0, 12'h0, 1, rnd128(), 1, rnd128(), 0, tag);
  endtask

  function automatic logic [11:0] pick_addr();
    case ($urandom() % 12)
      0: return 12'h500;  1: return 12'h504;  2: return 12'h508;  3: return 12'h50C;
      4: return 12'h510;  5: return 12'h514;  6: return 12'h518;  7: return 12'h51C;
      8: return 12'h520;  9: return 12'h4FC;  10: return 12'h502; default: return 12'h000;
    endcase
  endfunction

  initial begin
    rst_ni = 1'b0;
    host_valid_i = 0; host_we_i = 0; host_addr_i = '0; host_wdata_i = '0;
    eng_hkey_we_i = 0; eng_hkey_i = '0; eng_auth_we_i = 0; eng_auth_i = '0; key_load_i = 0;
    m_h = '0; m_a = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset hkey", hkey_o, '0);
    check("R1 reset auth", auth_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    fill("R6 engine load");
    idle("R10 hold");
    // R6 word order: low word of engine data appears in bits 31:0
    step(0, 0, 12'h0, 1, {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000},
         0, '0, 0, "R6 word order");
    check("R6 word0 bits 31:0", {96'd0, hkey_o[31:0]}, {96'd0, 32'hAAAA_0000});

    for (int w = 0; w < 4; w++) begin
      fill("R6 refill");
      step(1, 1, 12'(12'h500 + 4 * w), 0, '0, 0, '0, 0, "R2 hkey word clear, R4 auth kept");
      fill("R6 refill");
      step(1, 1, 12'(12'h510 + 4 * w), 0, '0, 0, '0, 0, "R3 auth word clear, R4 hkey kept");
    end

    fill("R6 refill");
    step(0, 1, 12'h500, 0, '0, 0, '0, 0, "R4 valid low");
    step(1, 1, 12'h520, 0, '0, 0, '0, 0, "R4 above range");
    step(1, 1, 12'h4FC, 0, '0, 0, '0, 0, "R4 below range");
    step(1, 1, 12'h502, 0, '0, 0, '0, 0, "R4 misaligned");
    step(1, 1, 12'h513, 0, '0, 0, '0, 0, "R4 misaligned auth");
    step(1, 0, 12'h500, 0, '0, 0, '0, 0, "R5 read hkey");
    step(1, 0, 12'h518, 0, '0, 0, '0, 0, "R5 read auth");

    step(0, 0, 12'h0, 0, '0, 0, '0, 1, "R7 key load");
    fill("R6 refill");
    step(1, 1, 12'h508, 1, rnd128(), 0, '0, 0, "R8 hkey clear beats engine");
    step(1, 1, 12'h51C, 0, '0, 1, rnd128(), 0, "R8 auth clear beats engine");
    fill("R6 refill");
    step(0, 0, 12'h0, 1, rnd128(), 1, rnd128(), 1, "R9 key load beats engine");
    idle("R10 hold zero");

    for (int i = 0; i < 400; i++) begin
      step($urandom() % 4 != 0, $urandom() % 2 == 0, pick_addr(),
           $urandom() % 3 == 0, rnd128(), $urandom() % 3 == 0, rnd128(),
           $urandom() % 10 == 0, "R8 R9 R10 random mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule